// File: doc/BRIEF.md
# Rotating-Diagonal Wavefront Allocator

This block matches a set of requesters to a set of equal-sized resources in one clock cycle. A square request matrix comes in, with one row for each requester and one column for each resource. A grant matrix goes out in the same cycle. The grant matrix is a valid matching: no requester gets more than one resource, no resource is handed out twice, and nothing is granted that was not asked for. A router uses this kind of block for switch or channel allocation, where many inputs compete for many outputs in the same cycle.

Cells are grouped into diagonals. Cell (i,j) belongs to diagonal (j - i) mod N. The block sweeps the diagonals in order, starting at a priority diagonal. Requests on one diagonal never share a row or a column, so all of them can be granted together. Each grant then claims its row and its column. The sweep ends after N diagonals. The sweep is written as N unrolled stages that start at the priority diagonal and never wrap back onto themselves, so the logic contains no combinational loop.

A registered priority pointer chooses the starting diagonal. It moves forward by one, wrapping at N, in every cycle that issues at least one grant. This rotation keeps any single diagonal from being favoured over time.

Top module: `wavefront_alloc`

## Requirements
- R1: Each row of the grant matrix has at most one bit set. Cell (i,j) is bit i*N+j of the `req` and `gnt` vectors.
- R2: Each column of the grant matrix has at most one bit set.
- R3: A grant bit is set only where the matching request bit is set.
- R4: Every requested cell on the priority diagonal (cells with (j - i) mod N equal to `prio`) is granted.
- R5: The matching is maximal. A request that is not granted has its row or its column already granted to another cell.
- R6: While `rst_n` is low, and in the first cycle after it rises, `prio` reads 0.
- R7: If any grant is issued in a cycle, `prio` takes the value (prio+1) mod N at the next clock edge.
- R8: An all-zero request matrix gives an all-zero grant matrix and leaves `prio` unchanged.
- R9: When two requests conflict, the one whose diagonal comes first counting up from `prio` (mod N) wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset. Clears the priority pointer |
| req | input | N*N | Request matrix. Bit i*N+j means requester i asks for resource j |
| gnt | output | N*N | Grant matrix, same layout as `req`. Combinational from `req` and `prio` |
| prio | output | $clog2(N) | Current priority diagonal |

## Verification
The grant matrix depends only on `req` and on the pointer register, so it is due in the same cycle as the request. The bench drives each request pattern just after a falling edge and reads `gnt` one time unit later, which is before the next rising edge. The pointer update is due one rising edge after a cycle that issued a grant. For that reason each vector stores the pointer value it expects to see at the time it is applied, and that value reflects all earlier vectors. Reset and idle-hold behaviour are checked by directed steps that read `prio` between clock edges.

// File: rtl/wavefront_alloc.sv
module wavefront_alloc #(
  parameter int N = 4,
  localparam int PW = (N > 1) ? $clog2(N) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N*N-1:0] req,
  output logic [N*N-1:0] gnt,
  output logic [PW-1:0]  prio
);

  logic [N-1:0] row_free, col_free;

  always_comb begin
    row_free = '1;
    col_free = '1;
    gnt      = '0;
    for (int k = 0; k < N; k++) begin
      for (int i = 0; i < N; i++) begin
        int c;
        c = (i + int'(prio) + k) % N;
        if (req[i*N+c] && row_free[i] && col_free[c]) begin
          gnt[i*N+c]  = 1'b1;
          row_free[i] = 1'b0;
          col_free[c] = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      prio <= '0;
    else if (|gnt)
      prio <= (prio == PW'(N-1)) ? '0 : prio + 1'b1;

endmodule

// File: rtl/wavefront_alloc_chk.sv
module wavefront_alloc_chk #(
  parameter int N = 4,
  localparam int PW = (N > 1) ? $clog2(N) : 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic [N*N-1:0] req,
  input logic [N*N-1:0] gnt,
  input logic [PW-1:0]  prio
);

  logic [N-1:0][N-1:0] colv;
  logic [N-1:0]        row_any, col_any;
  logic [N*N-1:0]      dmask, starved;

  always_comb begin
    colv    = '0;
    row_any = '0;
    col_any = '0;
    dmask   = '0;
    starved = '0;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        colv[j][i] = gnt[i*N+j];
        if (gnt[i*N+j]) begin
          row_any[i] = 1'b1;
          col_any[j] = 1'b1;
        end
      end
    for (int i = 0; i < N; i++) begin
      dmask[i*N + (i + int'(prio)) % N] = 1'b1;
      for (int j = 0; j < N; j++)
        if (req[i*N+j] && !gnt[i*N+j] && !row_any[i] && !col_any[j])
          starved[i*N+j] = 1'b1;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_lines
    p_row_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt[g*N +: N]));
    p_col_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(colv[g]));
  end

  p_grant_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);

  p_diag_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & dmask) == (req & dmask));

  p_maximal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    starved == '0);

  p_advance_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|gnt) |=> (prio == (($past(prio) == PW'(N-1)) ? '0 : $past(prio) + 1'b1)));

  p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0) |-> (gnt == '0));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt == '0) |=> $stable(prio));

endmodule

bind wavefront_alloc wavefront_alloc_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .gnt(gnt), .prio(prio)
);

// File: tb/tb_wavefront_alloc.sv
module tb_wavefront_alloc;

  localparam int N  = 4;
  localparam int PW = 2;
  localparam int NV = 11;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N*N-1:0] req = '0;
  logic [N*N-1:0] gnt;
  logic [PW-1:0]  prio;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  wavefront_alloc #(.N(N)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .gnt(gnt), .prio(prio)
  );

  // {expected prio when applied, req, expected gnt}; nibble i = row i
  localparam logic [PW+2*N*N-1:0] VEC [NV] = '{
    {2'd0, 16'hFFFF, 16'h8421},
    {2'd1, 16'hFFFF, 16'h1842},
    {2'd2, 16'h0003, 16'h0001},
    {2'd3, 16'h0011, 16'h0010},
    {2'd0, 16'h0000, 16'h0000},
    {2'd0, 16'h0013, 16'h0001},
    {2'd1, 16'h0013, 16'h0012},
    {2'd2, 16'hF000, 16'h2000},
    {2'd3, 16'h8888, 16'h0008},
    {2'd0, 16'h8888, 16'h8000},
    {2'd1, 16'h0FF0, 16'h0840}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R6: pointer held at zero during reset; R4 diagonal 0 fully granted
    req = 16'hFFFF;
    #12;
    check("R6 prio in reset", 32'(prio), 32'd0);
    check("R4 full req in reset", 32'(gnt), 32'h8421);
    @(negedge clk);
    req = '0;
    rst_n = 1'b1;
    #1;
    check("R6 prio after reset", 32'(prio), 32'd0);

    // R1 R2 R3 R4 R5 R7 R8 R9 vector walk
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      req = VEC[v][2*N*N-1:N*N];
      #1;
      check($sformatf("R7 prio before vec %0d", v), 32'(prio), 32'(VEC[v][PW+2*N*N-1:2*N*N]));
      check($sformatf("R1 R2 R3 R5 R9 gnt vec %0d", v), 32'(gnt), 32'(VEC[v][N*N-1:0]));
    end

    // R8: idle cycles keep pointer (vec 10 left it at 2 after the edge)
    @(negedge clk);
    req = '0;
    #1;
    check("R7 prio after last vec", 32'(prio), 32'd2);
    check("R8 zero req zero gnt", 32'(gnt), 32'd0);
    repeat (3) @(negedge clk);
    #1;
    check("R8 prio held while idle", 32'(prio), 32'd2);

    // R9: row 0 asks cols 1 and 3; prio 2 reaches diagonal 3 before 1
    req = 16'h000A;
    #1;
    check("R9 earlier diagonal wins", 32'(gnt), 32'h0008);
    @(negedge clk);
    req = '0;
    #1;
    check("R7 wrap 2 to 3", 32'(prio), 32'd3);

    // R6: mid-run reset returns pointer to zero
    rst_n = 1'b0;
    #1;
    check("R6 async reset clears prio", 32'(prio), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    req = 16'h1111;
    #1;
    check("R2 single column contention", 32'(gnt), 32'h0001);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule